// File: doc/BRIEF.md
# Multi-Channel Timer Compare Unit

This block holds a bank of compare channels that watch a free-running nanosecond time count supplied from outside. Each channel has a control register and a compare register. When the time count reaches or steps over the channel's active compare point, the channel sets its event flag. It can raise the shared interrupt and the shared request line. It also acts on its own output pin in the way its mode field selects: hold low, toggle, drive high, drive low, or give a one-cycle high pulse.

The compare register is double-buffered. Software writes the first compare point to arm the channel, then queues the following point while the first is still pending. At each event the queued value becomes the active one. The interrupt handler therefore always works one compare point ahead.

A status word at address 0 collects every channel's event flag, so an interrupt handler can find the source with one read. The time count is 31 bits wide and wraps modulo 2^31. All comparisons are made in that modular space.

Top module: `cmpt_bank`

## Requirements
- R1: After reset every control register, compare readback and status word read 0, all pins are low, and `irq` and `dma_req` are low.
- R2: Register map: address 0 is the status word, address 2+2c is channel c's control register and address 3+2c is its compare register. The control register has request enable at bit 0, mode at bits [5:2], interrupt enable at bit 6 and event flag at bit 7. `reg_rdata` shows the addressed register one cycle after `reg_addr` is presented.
- R3: An event occurs on a channel whose mode is nonzero and whose compare slot is armed, when the active compare value C satisfies 0 < (C - previous count) mod 2^31 <= (current count - previous count) mod 2^31. The previous count is the one sampled a cycle earlier. Its effects show one cycle after the count is presented. There is no event while the count stands still.
- R4: The event flag is cleared by writing 1 to bit 7 of the control register. Writing 0 to bit 7 leaves the flag as it is.
- R5: In mode 0 a channel produces no events and its pin is low.
- R6: In mode 0x5 the pin inverts at each event and holds at all other times.
- R7: In mode 0xF the pin goes high for exactly one cycle at each event.
- R8: Mode 0x6 drives the pin high at an event and mode 0x4 drives it low. Any other nonzero mode only sets the flag and leaves the pin unchanged.
- R9: The first compare write arms the active slot and a second write fills the preload slot; further writes replace the preload. At an event the preload moves to the active slot, or, with no preload, the channel disarms. The compare register reads back the active value.
- R10: Only the low 31 bits of a compare write are kept, so bit 31 always reads 0.
- R11: Writing 0 to a control register clears mode, enables and flag, empties both compare slots and drives the pin low.
- R12: `irq` is the OR over channels of flag AND interrupt enable. `dma_req` is the OR of flag AND request enable. Both drop in the cycle after the flag is cleared.
- R13: Bits [NCH-1:0] of the status word mirror the channel event flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_cnt | input | TW | Current nanosecond time count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cmp_pin | output | NCH | Per-channel compare output pins |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | Combined request line |

## Verification
A register write takes effect at the clock edge on which it is sampled. A count change yields its flag, pin and interrupt changes at the edge on which that count is sampled. A register read returns data one edge after the address is presented. The bench drives every input on the falling edge. After each write or count step it waits one falling edge before it samples pins and interrupts. After presenting an address it waits one falling edge before it samples `reg_rdata`. The one-cycle width of the pulse is checked on the next falling edge, with the count held still.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

  // Output behaviour codes held in the mode field of a control register.
  typedef enum logic [3:0] {
    MD_OFF   = 4'h0,
    MD_CLR   = 4'h4,
    MD_TGL   = 4'h5,
    MD_SET   = 4'h6,
    MD_PULSE = 4'hF
  } mode_e;

  // Control register image, MSB first: flag, irq enable, mode, spare, request enable.
  typedef struct packed {
    logic       flag;
    logic       ie;
    logic [3:0] mode;
    logic       rsvd;
    logic       dma;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int DATA_W = 32;

endpackage

// File: rtl/cmpt_cross.sv
// Detects that the time count passed a compare point between two samples,
// using modular distances so that wrap and multi-ns steps are covered.
module cmpt_cross #(
  parameter int TW = 31
) (
  input  logic [TW-1:0] prev_cnt,
  input  logic [TW-1:0] now_cnt,
  input  logic [TW-1:0] cmp_val,
  input  logic          prev_ok,
  output logic          hit
);
  logic [TW-1:0] d_cmp;
  logic [TW-1:0] d_step;

  always_comb begin
    d_cmp  = cmp_val - prev_cnt;
    d_step = now_cnt - prev_cnt;
    hit    = prev_ok && (d_cmp != '0) && (d_cmp <= d_step);
  end
endmodule

// File: rtl/cmpt_chan.sv
// One compare channel: control state, two-slot compare buffer, pin driver.
module cmpt_chan
  import cmpt_pkg::*;
#(
  parameter int TW = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     cnt_now,
  input  logic [TW-1:0]     cnt_prev,
  input  logic              prev_ok,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wd,
  input  logic              cmp_we,
  input  logic [TW-1:0]     cmp_wd,
  output ctrl_t             ctrl_o,
  output logic [TW-1:0]     act_o,
  output logic              act_vld_o,
  output logic              pin_o,
  output logic              ev_o
);
  ctrl_t         ctrl_q, c_n, wd_s;
  logic [TW-1:0] a_q, a_n, p_q, p_n;
  logic          av_q, av_n, pv_q, pv_n;
  logic          pin_q, pin_n;
  logic          hit, ev;

  assign wd_s = ctrl_t'(ctrl_wd);

  cmpt_cross #(.TW(TW)) u_cross (
    .prev_cnt (cnt_prev),
    .now_cnt  (cnt_now),
    .cmp_val  (a_q),
    .prev_ok  (prev_ok),
    .hit      (hit)
  );

  assign ev = hit && av_q && (ctrl_q.mode != MD_OFF);

  always_comb begin
    c_n   = ctrl_q;
    a_n   = a_q;
    p_n   = p_q;
    av_n  = av_q;
    pv_n  = pv_q;
    pin_n = pin_q;

    // a pulse lasts one cycle unless a new event renews it
    if (ctrl_q.mode == MD_PULSE) pin_n = 1'b0;

    if (ev) begin
      c_n.flag = 1'b1;
      if (pv_q) begin
        a_n  = p_q;
        pv_n = 1'b0;
      end else begin
        av_n = 1'b0;
      end
      case (ctrl_q.mode)
        MD_TGL:           pin_n = ~pin_q;
        MD_SET, MD_PULSE: pin_n = 1'b1;
        MD_CLR:           pin_n = 1'b0;
        default:          ;
      endcase
    end

    if (ctrl_q.mode == MD_OFF) pin_n = 1'b0;

    if (cmp_we) begin
      if (!av_n) begin
        a_n  = cmp_wd;
        av_n = 1'b1;
      end else begin
        p_n  = cmp_wd;
        pv_n = 1'b1;
      end
    end

    if (ctrl_we) begin
      if (ctrl_wd == '0) begin
        c_n   = '0;
        av_n  = 1'b0;
        pv_n  = 1'b0;
        pin_n = 1'b0;
      end else begin
        c_n.dma  = wd_s.dma;
        c_n.mode = wd_s.mode;
        c_n.ie   = wd_s.ie;
        c_n.rsvd = 1'b0;
        c_n.flag = (ctrl_q.flag & ~wd_s.flag) | ev;
        if (wd_s.mode == MD_OFF) begin
          av_n  = 1'b0;
          pv_n  = 1'b0;
          pin_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      a_q    <= '0;
      p_q    <= '0;
      av_q   <= 1'b0;
      pv_q   <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      ctrl_q <= c_n;
      a_q    <= a_n;
      p_q    <= p_n;
      av_q   <= av_n;
      pv_q   <= pv_n;
      pin_q  <= pin_n;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign act_o     = a_q;
  assign act_vld_o = av_q;
  assign pin_o     = pin_q;
  assign ev_o      = ev;
endmodule

// File: rtl/cmpt_bank.sv
// Bank of compare channels sharing one time count and one register port.
module cmpt_bank
  import cmpt_pkg::*;
#(
  parameter int  NCH = 4,
  parameter int  TW  = 31,
  localparam int AW  = $clog2(2*NCH+2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     tick_cnt,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    cmp_pin,
  output logic              irq,
  output logic              dma_req
);
  logic [TW-1:0]     prev_q;
  logic              prev_ok;
  logic [NCH-1:0]    flag_v, ie_v, dma_v, avld_v, ev_v;
  logic [4*NCH-1:0]  mode_v;
  logic [TW-1:0]     act_v  [NCH];
  ctrl_t             ctrl_v [NCH];
  logic [DATA_W-1:0] rd_n;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[DATA_W-1:TW];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      prev_ok <= 1'b0;
    end else begin
      prev_q  <= tick_cnt;
      prev_ok <= 1'b1;
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = AW'(2*gi+2);
    localparam logic [AW-1:0] A_CMP = AW'(2*gi+3);
    logic ctl_we, cmp_we;

    assign ctl_we = reg_wr && (reg_addr == A_CTL);
    assign cmp_we = reg_wr && (reg_addr == A_CMP);

    cmpt_chan #(.TW(TW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .cnt_now   (tick_cnt),
      .cnt_prev  (prev_q),
      .prev_ok   (prev_ok),
      .ctrl_we   (ctl_we),
      .ctrl_wd   (reg_wdata[CTRL_W-1:0]),
      .cmp_we    (cmp_we),
      .cmp_wd    (reg_wdata[TW-1:0]),
      .ctrl_o    (ctrl_v[gi]),
      .act_o     (act_v[gi]),
      .act_vld_o (avld_v[gi]),
      .pin_o     (cmp_pin[gi]),
      .ev_o      (ev_v[gi])
    );

    assign flag_v[gi]        = ctrl_v[gi].flag;
    assign ie_v[gi]          = ctrl_v[gi].ie;
    assign dma_v[gi]         = ctrl_v[gi].dma;
    assign mode_v[4*gi +: 4] = ctrl_v[gi].mode;
  end

  always_comb begin
    rd_n = '0;
    if (reg_addr == '0) rd_n[NCH-1:0] = flag_v;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == AW'(2*i+2)) rd_n[CTRL_W-1:0] = ctrl_v[i];
      if (reg_addr == AW'(2*i+3)) rd_n[TW-1:0]     = act_v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end

  assign irq     = |(flag_v & ie_v);
  assign dma_req = |(flag_v & dma_v);
endmodule

// File: rtl/cmpt_bank_chk.sv
module cmpt_bank_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   flag_v,
  input logic [NCH-1:0]   ie_v,
  input logic [NCH-1:0]   avld_v,
  input logic [NCH-1:0]   ev_v,
  input logic [4*NCH-1:0] mode_v,
  input logic [NCH-1:0]   cmp_pin,
  input logic             irq
);
  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flag_v & ie_v) == '0) |-> !irq);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r5_off_pin_low: assert property (@(posedge clk) disable iff (rst)
      (mode_v[4*i +: 4] == 4'h0) |=> !cmp_pin[i]);

    a_r3_flag_needs_arm: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_v[i]) |-> $past(avld_v[i]));

    a_r6_toggle_holds: assert property (@(posedge clk) disable iff (rst)
      ((mode_v[4*i +: 4] == 4'h5) && ($past(mode_v[4*i +: 4]) == 4'h5) && !$past(ev_v[i]))
        |-> $stable(cmp_pin[i]));

    a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
      ((mode_v[4*i +: 4] == 4'hF) && ($past(mode_v[4*i +: 4]) == 4'hF)
        && $past(cmp_pin[i]) && !$past(ev_v[i])) |-> !cmp_pin[i]);
  end
endmodule

bind cmpt_bank cmpt_bank_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .flag_v  (flag_v),
  .ie_v    (ie_v),
  .avld_v  (avld_v),
  .ev_v    (ev_v),
  .mode_v  (mode_v),
  .cmp_pin (cmp_pin),
  .irq     (irq)
);

// File: tb/sim_cmpt_bank.sv
`timescale 1ns/1ps
module sim_cmpt_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [30:0] tick_cnt = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  cmp_pin;
  logic        irq, dma_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  cmpt_bank u0 (
    .clk(clk), .rst(rst), .tick_cnt(tick_cnt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_pin(cmp_pin), .irq(irq), .dma_req(dma_req)
  );

  typedef struct packed {
    logic [30:0] p;
    logic [30:0] n;
    logic [30:0] c;
    logic        h;
  } vec_t;

  // previous count, current count, compare point, event expected
  localparam vec_t VEC [8] = '{
    '{31'd100,        31'd101, 31'd101,        1'b1},
    '{31'd100,        31'd108, 31'd105,        1'b1},
    '{31'd100,        31'd108, 31'd100,        1'b0},
    '{31'd100,        31'd108, 31'd109,        1'b0},
    '{31'h7FFFFFF0,   31'd8,   31'h7FFFFFFE,   1'b1},
    '{31'h7FFFFFF0,   31'd8,   31'd4,          1'b1},
    '{31'h7FFFFFF0,   31'd8,   31'd9,          1'b0},
    '{31'd500,        31'd500, 31'd500,        1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = 4'(a);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic setcnt(input logic [30:0] v);
    tick_cnt = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", {28'b0, cmp_pin}, 32'h0);
    chk("R1 irq/dma", {30'b0, irq, dma_req}, 32'h0);
    rd(0, rv); chk("R1 status", rv, 32'h0);
    rd(2, rv); chk("R1 ctrl0", rv, 32'h0);
    rd(3, rv); chk("R1 cmp0", rv, 32'h0);

    // R2 control layout readback
    wr(4, 32'h45);
    rd(4, rv); chk("R2 ctrl1 readback", rv, 32'h45);

    // R3 crossing table on channel 0, flag-only mode 2
    for (int k = 0; k < 8; k++) begin
      wr(2, 32'h0);
      setcnt(VEC[k].p);
      wr(2, 32'h08);
      wr(3, {1'b0, VEC[k].c});
      setcnt(VEC[k].n);
      rd(0, rv);
      chk("R3 crossing", {31'b0, rv[0]}, {31'b0, VEC[k].h});
    end
    chk("R8 flag-only pin holds", {31'b0, cmp_pin[0]}, 32'h0);
    wr(2, 32'h0);

    // R9 double buffer on channel 1
    wr(4, 32'h08);
    setcnt(31'd150);
    wr(5, 32'd200);
    wr(5, 32'd300);
    rd(5, rv); chk("R9 active first", rv, 32'd200);
    setcnt(31'd250);
    rd(0, rv); chk("R9 first event", {31'b0, rv[1]}, 32'h1);
    rd(5, rv); chk("R9 preload moved", rv, 32'd300);
    wr(4, 32'h88);
    rd(0, rv); chk("R4 w1c clears", {31'b0, rv[1]}, 32'h0);
    setcnt(31'd350);
    rd(0, rv); chk("R9 second event", {31'b0, rv[1]}, 32'h1);
    wr(4, 32'h88);
    setcnt(31'h7FFFFFFF);
    setcnt(31'd400);
    rd(0, rv); chk("R9 disarmed", {31'b0, rv[1]}, 32'h0);
    wr(5, 32'd1000);
    wr(5, 32'd2000);
    wr(5, 32'd3000);
    setcnt(31'd1100);
    rd(5, rv); chk("R9 preload overwritten", rv, 32'd3000);
    wr(4, 32'h08);
    rd(0, rv); chk("R4 zero bit keeps flag", {31'b0, rv[1]}, 32'h1);
    wr(4, 32'h0);

    // R6 toggle on channel 2
    wr(6, 32'h14);
    wr(7, 32'd1500);
    wr(7, 32'd2500);
    setcnt(31'd1600);
    chk("R6 toggle high", {31'b0, cmp_pin[2]}, 32'h1);
    setcnt(31'd2000);
    chk("R6 holds between events", {31'b0, cmp_pin[2]}, 32'h1);
    setcnt(31'd2600);
    chk("R6 toggle low", {31'b0, cmp_pin[2]}, 32'h0);

    // R7 pulse on channel 3
    wr(8, 32'h3C);
    wr(9, 32'd3000);
    setcnt(31'd3000);
    chk("R7 pulse high", {31'b0, cmp_pin[3]}, 32'h1);
    setcnt(31'd3000);
    chk("R7 pulse one cycle", {31'b0, cmp_pin[3]}, 32'h0);

    // R8 set then clear on channel 0
    wr(2, 32'h18);
    wr(3, 32'd5000);
    wr(3, 32'd6000);
    setcnt(31'd5000);
    chk("R8 set mode", {31'b0, cmp_pin[0]}, 32'h1);
    wr(2, 32'h10);
    setcnt(31'd6000);
    chk("R8 clear mode", {31'b0, cmp_pin[0]}, 32'h0);

    // R13 status mirrors flags: ch0, ch2, ch3 set
    rd(0, rv); chk("R13 status word", rv, 32'hD);

    // R5 mode 0 produces nothing
    wr(5, 32'd7000);
    setcnt(31'd7100);
    rd(0, rv); chk("R5 no event in mode 0", {31'b0, rv[1]}, 32'h0);
    chk("R5 pin low", {31'b0, cmp_pin[1]}, 32'h0);

    // R12 and R11 on channel 3
    wr(8, 32'h0);
    wr(8, 32'h59);
    wr(9, 32'd8000);
    wr(9, 32'd9000);
    setcnt(31'd8000);
    chk("R12 irq and request up", {30'b0, irq, dma_req}, 32'h3);
    chk("R8 set mode pin", {31'b0, cmp_pin[3]}, 32'h1);
    wr(8, 32'hD9);
    chk("R12 irq and request drop", {30'b0, irq, dma_req}, 32'h0);
    chk("R4 pin unaffected by w1c", {31'b0, cmp_pin[3]}, 32'h1);
    wr(8, 32'h0);
    chk("R11 pin low", {31'b0, cmp_pin[3]}, 32'h0);
    rd(8, rv); chk("R11 ctrl cleared", rv, 32'h0);
    setcnt(31'd9500);
    rd(0, rv); chk("R11 buffers emptied", rv, 32'h5);

    // R10 only 31 bits kept
    wr(2, 32'h0);
    wr(3, 32'hFFFFFFFF);
    rd(3, rv); chk("R10 bit 31 dropped", rv, 32'h7FFFFFFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule